// File: doc/BRIEF.md
# Clock-Output Power-Down Sequencer

This block decides when one differential clock output pair stops and when it starts again, under control of an asynchronous power-down pin. The pin is compared against a polarity strap to form a request. The request passes through a two-flop synchroniser. It is accepted only after two consecutive rising edges of the complement output have sampled it active. The pair then stops on the next falling edge of the complement output, so that no short pulse ever leaves the block.

While stopped, the pair is parked in one of two ways, selected by a drive-mode bit. Either the true leg is driven high and the complement leg floats, or both legs float. When the request is released with both legs floating, the true leg is first driven high for a programmable window. The output clock restarts only once the PLL reports lock, and it always restarts with a full low phase. A done flag reports a completed restart. An error flag reports that lock did not arrive within the stable-clock timeout.

The output clock runs at half the reference clock rate. Each output leg comes with its own enable, which stands in for a tri-state driver.

Top module: `clk_pd_seq`

## Requirements
- R1: Power-down is requested when `pd_pin_i` equals `pd_pol_i`. When the two differ, the output runs normally.
- R2: The request is synchronised by two flops. After that, exactly two rising edges of `clk_c_o` must sample it active before the stop is committed.
- R3: While running, `clk_t_o` is always the inverse of `clk_c_o`. The stop happens on a falling edge of `clk_c_o`, and it leaves `clk_t_o` at 1 with no truncated pulse.
- R4: When stopped with `park_float_i`=0 and the output enabled, `clk_t_oe_o`=1 with `clk_t_o`=1, and `clk_c_oe_o`=0.
- R5: When stopped with `park_float_i`=1, `clk_t_oe_o`=0 and `clk_c_oe_o`=0.
- R6: On release with `park_float_i`=1, `clk_t_oe_o` rises within 4 reference cycles of the pin change. The true leg is then held high and static for at least DRV_CYC and at most DRV_CYC+3 cycles before the clock restarts.
- R7: The clock restarts only while `pll_lock_i`=1. The first cycle with `clk_c_oe_o`=1 after a restart has `clk_t_o`=0.
- R8: `restart_done_o` is 1 exactly while the output is running after a restart, and 0 when stopped or in reset.
- R9: `lock_err_o` sets when the clock has not restarted STABLE_CYC cycles after a release. It is cleared by the next release or by reset.
- R10: `out_en_i`=0 forces `clk_t_oe_o`=0 and `clk_c_oe_o`=0 in every state.
- R11: Reset (`rst_ni`=0) floats both legs and clears both flags. After reset, an inactive request leads to the parked-high state while the block waits for lock.
- R12: If the request drops before the second qualifying sample, the entry is abandoned and the output keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_pin_i | input | 1 | Asynchronous power-down pin |
| pd_pol_i | input | 1 | Polarity strap; request when pin equals strap |
| park_float_i | input | 1 | Drive-mode bit: 1 floats both legs when stopped |
| out_en_i | input | 1 | Per-output enable |
| pll_lock_i | input | 1 | PLL lock indication |
| clk_t_o | output | 1 | True clock level |
| clk_c_o | output | 1 | Complement clock level |
| clk_t_oe_o | output | 1 | True leg drive enable |
| clk_c_oe_o | output | 1 | Complement leg drive enable |
| restart_done_o | output | 1 | Restart complete, clock running |
| lock_err_o | output | 1 | Lock not reached within the stable timeout |

## Verification
The bench counts the complement rising edges that occur after the synchroniser has settled, and expects exactly two. A block that skipped qualification would stop after one edge, and one that waited for a third edge would overshoot. A two-cycle request pulse checks the abort path: a design that latched a partial qualification would stop the clock anyway. On release in floating mode, the bench measures the length of the drive-high window and the phase of the first restarted cycle. A design that restarted on a high phase would emit a runt. With lock held low, the bench checks both that the error flag asserts and that no clock ever escapes the block.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_STOP  = 3'd2,
    ST_DRIVE = 3'd3,
    ST_WAIT  = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pd_win_cnt.sv
module pd_win_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !done_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import clk_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      park_float_i,
  input  logic      pll_lock_i,
  input  logic      drv_done_i,
  input  logic      stb_done_i,
  output pd_state_e state_o,
  output logic      ph_o,
  output logic      drv_clr_o,
  output logic      drv_en_o,
  output logic      stb_clr_o,
  output logic      stb_en_o,
  output logic      done_o,
  output logic      err_o
);
  pd_state_e st_q, st_d;
  logic       ph_q, ph_d;
  logic [1:0] qual_q, qual_d;
  logic       done_q, done_d;
  logic       err_q, err_d;
  logic       drv_clr, stb_clr;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    qual_d  = qual_q;
    done_d  = done_q;
    drv_clr = 1'b0;
    stb_clr = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (!req_i) begin
          st_d    = ST_WAIT;
          stb_clr = 1'b1;
        end
      end
      ST_RUN: begin
        // committed stop lands on complement high-to-low (ph 0 -> 1)
        if (qual_q == 2'd2 && !ph_q) begin
          st_d   = ST_STOP;
          done_d = 1'b0;
          qual_d = 2'd0;
        end else begin
          ph_d = ~ph_q;
          // complement rising edge: sample request
          if (ph_q) qual_d = req_i ? qual_q + 2'd1 : 2'd0;
        end
      end
      ST_STOP: begin
        qual_d = 2'd0;
        if (!req_i) begin
          stb_clr = 1'b1;
          if (park_float_i) begin
            st_d    = ST_DRIVE;
            drv_clr = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_DRIVE: begin
        if (req_i)           st_d = ST_STOP;
        else if (drv_done_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (req_i) st_d = ST_STOP;
        else if (pll_lock_i) begin
          st_d   = ST_RUN;
          ph_d   = 1'b0;
          qual_d = 2'd0;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (stb_clr) err_d = 1'b0;
    else if ((st_q == ST_DRIVE || st_q == ST_WAIT) && stb_done_i) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      ph_q   <= 1'b0;
      qual_q <= 2'd0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      qual_q <= qual_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign state_o   = st_q;
  assign ph_o      = ph_q;
  assign drv_clr_o = drv_clr;
  assign drv_en_o  = (st_q == ST_DRIVE);
  assign stb_clr_o = stb_clr;
  assign stb_en_o  = (st_q == ST_DRIVE) || (st_q == ST_WAIT);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pd_out.sv
module pd_out
  import clk_pd_pkg::*;
(
  input  pd_state_e state_i,
  input  logic      ph_i,
  input  logic      park_float_i,
  input  logic      out_en_i,
  output logic      t_o,
  output logic      c_o,
  output logic      t_oe_o,
  output logic      c_oe_o
);
  always_comb begin
    t_o    = 1'b1;
    c_o    = 1'b0;
    t_oe_o = 1'b0;
    c_oe_o = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        t_o    = ph_i;
        c_o    = ~ph_i;
        t_oe_o = out_en_i;
        c_oe_o = out_en_i;
      end
      ST_STOP:           t_oe_o = out_en_i & ~park_float_i;
      ST_DRIVE, ST_WAIT: t_oe_o = out_en_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/clk_pd_seq.sv
module clk_pd_seq
  import clk_pd_pkg::*;
#(
  parameter int DRV_CYC    = 15000,
  parameter int STABLE_CYC = 50000,
  parameter int SYNC_STG   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_pin_i,
  input  logic pd_pol_i,
  input  logic park_float_i,
  input  logic out_en_i,
  input  logic pll_lock_i,
  output logic clk_t_o,
  output logic clk_c_o,
  output logic clk_t_oe_o,
  output logic clk_c_oe_o,
  output logic restart_done_o,
  output logic lock_err_o
);
  logic      req_raw, req_s;
  pd_state_e st;
  logic      ph;
  logic      drv_clr, drv_en, drv_done;
  logic      stb_clr, stb_en, stb_done;

  assign req_raw = ~(pd_pin_i ^ pd_pol_i);

  pd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (req_s)
  );

  pd_win_cnt #(.LIMIT(DRV_CYC)) u_drv_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (drv_clr),
    .en_i  (drv_en),
    .done_o(drv_done)
  );

  pd_win_cnt #(.LIMIT(STABLE_CYC)) u_stb_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (stb_clr),
    .en_i  (stb_en),
    .done_o(stb_done)
  );

  pd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_s),
    .park_float_i(park_float_i),
    .pll_lock_i  (pll_lock_i),
    .drv_done_i  (drv_done),
    .stb_done_i  (stb_done),
    .state_o     (st),
    .ph_o        (ph),
    .drv_clr_o   (drv_clr),
    .drv_en_o    (drv_en),
    .stb_clr_o   (stb_clr),
    .stb_en_o    (stb_en),
    .done_o      (restart_done_o),
    .err_o       (lock_err_o)
  );

  pd_out u_out (
    .state_i     (st),
    .ph_i        (ph),
    .park_float_i(park_float_i),
    .out_en_i    (out_en_i),
    .t_o         (clk_t_o),
    .c_o         (clk_c_o),
    .t_oe_o      (clk_t_oe_o),
    .c_oe_o      (clk_c_oe_o)
  );
endmodule

// File: rtl/clk_pd_seq_chk.sv
module clk_pd_seq_chk
  import clk_pd_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      park_float_i,
  input logic      out_en_i,
  input logic      pll_lock_i,
  input logic      clk_t_o,
  input logic      clk_c_o,
  input logic      clk_t_oe_o,
  input logic      clk_c_oe_o,
  input logic      restart_done_o,
  input pd_state_e st
);
  a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_c_oe_o |-> (clk_t_o != clk_c_o));

  a_r3_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_c_oe_o) && out_en_i && $past(out_en_i)) |-> clk_t_o);

  a_r4_park_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_STOP && !park_float_i && out_en_i) |-> (clk_t_oe_o && clk_t_o && !clk_c_oe_o));

  a_r5_park_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_STOP && park_float_i) |-> (!clk_t_oe_o && !clk_c_oe_o));

  a_r7_need_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restart_done_o) |-> $past(pll_lock_i));

  a_r7_low_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_c_oe_o) && $past(out_en_i)) |-> !clk_t_o);

  a_r8_done_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_done_o == (st == ST_RUN));

  a_r10_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (!clk_t_oe_o && !clk_c_oe_o));
endmodule

bind clk_pd_seq clk_pd_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .park_float_i  (park_float_i),
  .out_en_i      (out_en_i),
  .pll_lock_i    (pll_lock_i),
  .clk_t_o       (clk_t_o),
  .clk_c_o       (clk_c_o),
  .clk_t_oe_o    (clk_t_oe_o),
  .clk_c_oe_o    (clk_c_oe_o),
  .restart_done_o(restart_done_o),
  .st            (st)
);

// File: tb/clk_pd_seq_tb_top.sv
module clk_pd_seq_tb_top;
  localparam int DRV = 8;
  localparam int STB = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_pin_i = 1'b1, pd_pol_i = 1'b0, park_float_i = 1'b0;
  logic out_en_i = 1'b1, pll_lock_i = 1'b0;
  logic clk_t_o, clk_c_o, clk_t_oe_o, clk_c_oe_o, restart_done_o, lock_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  clk_pd_seq #(.DRV_CYC(DRV), .STABLE_CYC(STB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_pin_i(pd_pin_i), .pd_pol_i(pd_pol_i),
    .park_float_i(park_float_i), .out_en_i(out_en_i), .pll_lock_i(pll_lock_i),
    .clk_t_o(clk_t_o), .clk_c_o(clk_c_o), .clk_t_oe_o(clk_t_oe_o),
    .clk_c_oe_o(clk_c_oe_o), .restart_done_o(restart_done_o), .lock_err_o(lock_err_o)
  );

  // {pol, pin, mode, en, exp_t_oe, exp_c_oe, exp_toggle}
  localparam logic [6:0] VEC [8] = '{
    7'b0_1_0_1_1_1_1,  // R1 run
    7'b0_0_0_1_1_0_0,  // R1 R4 park high
    7'b1_0_0_1_1_1_1,  // R1 run, strap inverted
    7'b1_1_1_1_0_0_0,  // R5 float
    7'b1_0_1_1_1_1_1,  // R6 release floating
    7'b1_1_0_0_0_0_0,  // R10 parked, disabled
    7'b0_1_0_1_1_1_1,  // run
    7'b0_1_0_0_0_0_0   // R10 running, disabled
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rises, n, m;
    logic prev, t0;
    // R11 reset state
    wait_cyc(3);
    check("R11", "t_oe in reset", clk_t_oe_o, 0);
    check("R11", "c_oe in reset", clk_c_oe_o, 0);
    check("R11", "done in reset", restart_done_o, 0);
    check("R11", "err in reset", lock_err_o, 0);
    rst_ni = 1'b1;
    wait_cyc(3);
    check("R11", "parked high after reset", clk_t_oe_o, 1);
    check("R11", "c floats after reset", clk_c_oe_o, 0);
    wait_cyc(7);
    check("R9", "no error before timeout", lock_err_o, 0);
    wait_cyc(20);
    check("R9", "error after timeout", lock_err_o, 1);
    check("R7", "no clock without lock", clk_c_oe_o, 0);
    check("R8", "done low without lock", restart_done_o, 0);
    pll_lock_i = 1'b1;
    n = 0;
    while (!clk_c_oe_o && n < 10) begin @(negedge clk_i); n++; end
    check("R7", "restart begins low", clk_t_o, 0);
    check("R8", "done after restart", restart_done_o, 1);

    // table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      {pd_pol_i, pd_pin_i, park_float_i, out_en_i} = VEC[i][6:3];
      wait_cyc(60);
      check("R1", $sformatf("vec%0d t_oe", i), clk_t_oe_o, VEC[i][2]);
      check("R1", $sformatf("vec%0d c_oe", i), clk_c_oe_o, VEC[i][1]);
      if (VEC[i][0]) begin
        t0 = clk_t_o;
        @(negedge clk_i);
        check("R3", $sformatf("vec%0d toggles", i), int'(clk_t_o != t0), 1);
        check("R3", $sformatf("vec%0d complement", i), int'(clk_t_o != clk_c_o), 1);
      end
    end
    out_en_i = 1'b1; pd_pol_i = 1'b0; pd_pin_i = 1'b1; park_float_i = 1'b0;
    wait_cyc(20);

    // R2: exactly two complement rises after synchroniser
    pd_pin_i = 1'b0;
    wait_cyc(2);
    prev = clk_c_o;
    rises = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (!clk_c_oe_o) break;
      if (clk_c_o && !prev) rises++;
      prev = clk_c_o;
    end
    check("R2", "complement rises before stop", rises, 2);
    check("R3", "true high after stop", clk_t_o, 1);
    check("R4", "true driven after stop", clk_t_oe_o, 1);
    check("R8", "done cleared when stopped", restart_done_o, 0);
    pd_pin_i = 1'b1;
    wait_cyc(20);

    // R12: short request aborts
    pd_pin_i = 1'b0;
    wait_cyc(2);
    pd_pin_i = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (!clk_c_oe_o) n++;
    end
    check("R12", "stopped cycles after short pulse", n, 0);
    check("R12", "done still high", restart_done_o, 1);

    // R5/R6/R7: floating park and release
    park_float_i = 1'b1;
    pd_pin_i = 1'b0;
    wait_cyc(30);
    check("R5", "t_oe floating", clk_t_oe_o, 0);
    check("R5", "c_oe floating", clk_c_oe_o, 0);
    pd_pin_i = 1'b1;
    n = 0;
    while (!clk_t_oe_o && n < 10) begin @(negedge clk_i); n++; end
    check("R6", "drive-high within 4 cycles", int'(n <= 4), 1);
    m = 0;
    while (clk_t_oe_o && !clk_c_oe_o && clk_t_o && m < 100) begin m++; @(negedge clk_i); end
    check("R6", "drive window length in range", int'(m >= DRV && m <= DRV + 3), 1);
    check("R7", "clock resumed", clk_c_oe_o, 1);
    check("R7", "first restart phase low", clk_t_o, 0);
    check("R9", "error cleared by release", lock_err_o, 0);
    park_float_i = 1'b0;
    wait_cyc(5);

    // R11: reset while running
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11", "t_oe after reset mid-run", clk_t_oe_o, 0);
    check("R11", "c_oe after reset mid-run", clk_c_oe_o, 0);
    check("R11", "done after reset mid-run", restart_done_o, 0);
    rst_ni = 1'b1;
    wait_cyc(5);
    finish_run();
  end
endmodule